// File: doc/BRIEF.md
# Token Shift Register Row Selector

This block selects one row of a pixel matrix at a time by moving a single token along a chain of flip-flops, one stage per row. While a stage holds the token, and only in the live half of its time slot, that row's gate and clear drive outputs follow two externally supplied strobes. Rows are visited strictly in ascending order; the chain offers no way to skip a row or revisit one out of turn.

The chain keeps only transient state. A small controller steps it, re-injects a fresh token at the chain input once per pass, and watches the chain output. A correct chain returns exactly one token at the end of every pass. A lost token or a stray extra token sets a sticky upset flag that only reset clears. The controller's injection bit leaves the block on `tok_drive`, and the chain input comes back in on `tok_in`, so the serial link between controller and chain is visible at the boundary. Normally the two are wired together.

The controller is a three-state machine. After reset it is in `CTL_FIRST`, where it makes the first injection and the first shift. The transition *first→dead* is always taken. From then on it alternates between two states. `CTL_DEAD` is a settling cycle in which no row is driven. `CTL_LIVE` is the cycle in which the current row may be driven. Taking *dead→live* enables the row outputs. Taking *live→dead* performs the shift. A full pass therefore lasts 2·ROWS clocks.

Top module: `tsr_row_selector`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, every stage is empty: all `gate_row` and `clear_row` bits, `tok_out` and `upset_err` are 0.
- R2: `tok_drive` is 1 in the first cycle after reset release and then every 2·ROWS clocks (cycles 0, 256, 512, … counting clock edges since release, ROWS=128). It is 0 in every other cycle.
- R3: After clock edge e (e even, e ≥ 2) row r = ((e−2)/2) mod ROWS is the live row. Bit r of the row outputs is the only bit that can be 1, so rows advance by one in ascending order per two clocks.
- R4: In every odd-numbered cycle (dead cycle) all `gate_row` and `clear_row` bits are 0. No row output is high in two consecutive cycles.
- R5: `gate_row[r]` is 1 exactly when row r is live and `gate_strb` is 1. With `gate_strb` low, every `gate_row` bit is 0.
- R6: `clear_row[r]` is 1 exactly when row r is live and `clear_strb` is 1, independently of `gate_strb`.
- R7: `tok_out` (the last stage) is 1 exactly in cycles e with e ≥ 255 and e mod 256 ∈ {255, 0}.
- R8: A token entering the chain while `tok_drive` is 0 makes `upset_err` rise when that token reaches the last stage. A stray token captured at edge 21 raises the flag at edge 276.
- R9: A missing injection makes `upset_err` rise one edge after the pass end at which no token appears. Suppressing the cycle-256 injection raises the flag at edge 512.
- R10: `upset_err` stays 1 until reset, and reset clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_strb | input | 1 | Strobe qualifying the gate drive of the live row |
| clear_strb | input | 1 | Strobe qualifying the clear drive of the live row |
| tok_in | input | 1 | Serial input of the chain |
| tok_drive | output | 1 | Controller's injection bit, normally looped back to `tok_in` |
| tok_out | output | 1 | Serial output of the chain (last stage) |
| gate_row | output | ROWS | Per-row gate drive |
| clear_row | output | ROWS | Per-row clear drive |
| upset_err | output | 1 | Sticky chain-upset flag |

## Verification
The hardest condition to reach from the ports is a corrupted chain, because in normal wiring the controller alone feeds it. The bench breaks the loop between `tok_drive` and `tok_in`. In one run it ORs an extra 1 into the chain input in a live cycle mid-pass, at edge 21. In another run it masks the second injection, at edge 256. It then checks that the flag stays low right up to the edge at which the stray or missing token reaches the chain end, and high from that edge on.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
    typedef enum logic [1:0] {
        CTL_FIRST = 2'd0,
        CTL_DEAD  = 2'd1,
        CTL_LIVE  = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/tsr_chain.sv
module tsr_chain #(
    parameter int ROWS = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift,
    input  logic            ser_in,
    output logic [ROWS-1:0] stage,
    output logic            ser_out
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stage <= '0;
        else if (shift)
            stage <= {stage[ROWS-2:0], ser_in};
    end

    assign ser_out = stage[ROWS-1];

    AST_HOLD_WITHOUT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(stage)); // R3
endmodule

// File: rtl/tsr_ctrl.sv
module tsr_ctrl
    import tsr_pkg::*;
#(
    parameter int ROWS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_return,
    output logic shift,
    output logic tok_drive,
    output logic live,
    output logic upset_err
);
    localparam int CW = $clog2(ROWS);
    localparam logic [CW-1:0] LAST = CW'(ROWS - 1);

    ctl_state_t    state, state_nx;
    logic [CW-1:0] shift_cnt;
    logic          check_en, expect_tok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= CTL_FIRST;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CTL_FIRST: state_nx = CTL_DEAD;
            CTL_DEAD:  state_nx = CTL_LIVE;
            CTL_LIVE:  state_nx = CTL_DEAD;
            default:   state_nx = CTL_FIRST;
        endcase
    end

    // outputs per state
    always_comb begin
        shift      = 1'b0;
        tok_drive  = 1'b0;
        live       = 1'b0;
        check_en   = 1'b0;
        expect_tok = 1'b0;
        unique case (state)
            CTL_FIRST: begin
                shift     = 1'b1;
                tok_drive = 1'b1;
            end
            CTL_DEAD: begin
                check_en   = 1'b1;
                expect_tok = (shift_cnt == '0);
            end
            CTL_LIVE: begin
                shift      = 1'b1;
                live       = 1'b1;
                tok_drive  = (shift_cnt == '0);
                check_en   = 1'b1;
                expect_tok = (shift_cnt == '0);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shift_cnt <= '0;
        else if (shift)
            shift_cnt <= (shift_cnt == LAST) ? '0 : shift_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            upset_err <= 1'b0;
        else if (check_en && (ser_return != expect_tok))
            upset_err <= 1'b1;
    end

    AST_DRIVE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tok_drive |=> !tok_drive); // R2
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        upset_err |=> upset_err); // R10
    AST_LIVE_NOT_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
        live |=> !live); // R4
endmodule

// File: rtl/tsr_row_drive.sv
module tsr_row_drive #(
    parameter int ROWS = 128
) (
    input  logic [ROWS-1:0] stage,
    input  logic            live,
    input  logic            gate_strb,
    input  logic            clear_strb,
    output logic [ROWS-1:0] gate_row,
    output logic [ROWS-1:0] clear_row
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign gate_row[r]  = stage[r] & live & gate_strb;
        assign clear_row[r] = stage[r] & live & clear_strb;
    end
endmodule

// File: rtl/tsr_row_selector.sv
module tsr_row_selector #(
    parameter int ROWS = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gate_strb,
    input  logic            clear_strb,
    input  logic            tok_in,
    output logic            tok_drive,
    output logic            tok_out,
    output logic [ROWS-1:0] gate_row,
    output logic [ROWS-1:0] clear_row,
    output logic            upset_err
);
    logic            shift, live;
    logic [ROWS-1:0] stage;

    tsr_ctrl #(.ROWS(ROWS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_return (tok_out),
        .shift      (shift),
        .tok_drive  (tok_drive),
        .live       (live),
        .upset_err  (upset_err)
    );

    tsr_chain #(.ROWS(ROWS)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift   (shift),
        .ser_in  (tok_in),
        .stage   (stage),
        .ser_out (tok_out)
    );

    tsr_row_drive #(.ROWS(ROWS)) u_drive (
        .stage      (stage),
        .live       (live),
        .gate_strb  (gate_strb),
        .clear_strb (clear_strb),
        .gate_row   (gate_row),
        .clear_row  (clear_row)
    );

    AST_GATE_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (|gate_row) |=> !(|gate_row)); // R4
    AST_CLEAR_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (|clear_row) |=> !(|clear_row)); // R4
    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |-> (tok_out == 1'b0 && upset_err == 1'b0)); // R1
endmodule

// File: tb/test_tsr_row_selector.sv
`timescale 1ns/1ps
module test_tsr_row_selector;
    localparam int ROWS = 128;
    localparam int PASS = 2 * ROWS;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            gate_strb = 1'b0, clear_strb = 1'b0;
    logic            extra = 1'b0, drop = 1'b0;
    logic            tok_in, tok_drive, tok_out, upset_err;
    logic [ROWS-1:0] gate_row, clear_row;

    int checks = 0;
    int errors = 0;
    int e = 0;

    assign tok_in = (tok_drive & ~drop) | extra;

    always #2.5 clk = ~clk;

    tsr_row_selector #(.ROWS(ROWS)) i_tsr_row_selector (
        .clk(clk), .rst_n(rst_n), .gate_strb(gate_strb), .clear_strb(clear_strb),
        .tok_in(tok_in), .tok_drive(tok_drive), .tok_out(tok_out),
        .gate_row(gate_row), .clear_row(clear_row), .upset_err(upset_err)
    );

    task automatic chk(string tag, logic [ROWS-1:0] act, logic [ROWS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at edge %0d: actual %h expected %h", tag, e, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        e++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; extra = 1'b0; drop = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset tok_out", ROWS'(tok_out), '0);
        chk("R1 reset gate_row", gate_row, '0);
        rst_n = 1'b1;
        e = 0;
        #0.1;
    endtask

    // full expected-value check of the current cycle
    task automatic check_cycle();
        logic [ROWS-1:0] exp_g, exp_c, one;
        bit live_now;
        int row;
        live_now = (e >= 2) && (e % 2 == 0);
        row = live_now ? ((e - 2) / 2) % ROWS : 0;
        one = live_now ? (ROWS'(1) << row) : '0;
        exp_g = gate_strb  ? one : '0;
        exp_c = clear_strb ? one : '0;
        chk(live_now ? "R5 gate live" : "R4 gate dead", gate_row, exp_g);
        chk(live_now ? "R6 clear live" : "R4 clear dead", clear_row, exp_c);
        chk("R7 tok_out", ROWS'(tok_out),
            ROWS'((e >= 255) && ((e % PASS == 255) || (e % PASS == 0))));
        chk("R2 tok_drive", ROWS'(tok_drive), ROWS'(e % PASS == 0));
        chk("R3 no upset", ROWS'(upset_err), '0);
    endtask

    task automatic test_reset();
        do_reset();
        chk("R1 first cycle gate", gate_row, '0);
        chk("R1 first cycle clear", clear_row, '0);
        chk("R1 first cycle err", ROWS'(upset_err), '0);
        chk("R2 first drive", ROWS'(tok_drive), ROWS'(1));
    endtask

    task automatic test_gate_pass();
        do_reset();
        gate_strb = 1'b1; clear_strb = 1'b0;
        check_cycle();
        for (int k = 0; k < 2 * PASS + 8; k++) begin
            tick();
            check_cycle();
        end
    endtask

    task automatic test_mixed_strobes();
        do_reset();
        for (int k = 0; k < PASS + 12; k++) begin
            gate_strb  = ((e + 1) % 6) < 4;
            clear_strb = ((e + 1) % 10) >= 5;
            tick();
            check_cycle();
        end
        gate_strb = 1'b0; clear_strb = 1'b1;
        for (int k = 0; k < 40; k++) begin
            tick();
            check_cycle();
        end
    endtask

    task automatic test_strobes_low();
        do_reset();
        gate_strb = 1'b0; clear_strb = 1'b0;
        for (int k = 0; k < PASS + 4; k++) begin
            tick();
            chk("R5 gate with strobe low", gate_row, '0);
            chk("R6 clear with strobe low", clear_row, '0);
        end
    endtask

    task automatic test_extra_token();
        do_reset();
        gate_strb = 1'b1; clear_strb = 1'b1;
        while (e < 20) tick();
        extra = 1'b1;
        tick();
        extra = 1'b0;
        while (e < 274) tick();
        chk("R8 flag low before stray arrives", ROWS'(upset_err), '0);
        tick(); tick();
        chk("R8 flag raised by stray token", ROWS'(upset_err), ROWS'(1));
        while (e < 700) tick();
        chk("R10 flag sticky", ROWS'(upset_err), ROWS'(1));
        do_reset();
        chk("R10 reset clears flag", ROWS'(upset_err), '0);
    endtask

    task automatic test_missing_token();
        do_reset();
        while (e < 256) tick();
        chk("R2 second drive", ROWS'(tok_drive), ROWS'(1));
        drop = 1'b1;
        tick();
        drop = 1'b0;
        while (e < 510) tick();
        chk("R9 flag low before pass end", ROWS'(upset_err), '0);
        tick(); tick();
        chk("R9 flag raised by missing token", ROWS'(upset_err), ROWS'(1));
        chk("R9 tok_out empty", ROWS'(tok_out), '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_gate_pass();
        test_mixed_strobes();
        test_strobes_low();
        test_extra_token();
        test_missing_token();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule